// File: doc/BRIEF.md
# Block-Wise Noise Sigma Estimator

This block estimates the noise standard deviation of a stream of zero-mean detail coefficients, such as the output of one wavelet scale. Samples arrive with a valid qualifier. A block-end strobe marks the last sample of each block. The block keeps a running sum of squared samples for the current block. At each block end it files that partial energy into a ring of `R_SIG` slots, or it leaves the ring alone.

After every block end the ring slots are summed into a window energy. The window energy is multiplied by a fixed-point reciprocal of `(BLK_LEN*R_SIG - 1)`, which gives a variance. A bit-serial integer square root then turns the variance into sigma. A denoising threshold of about 3.9 times sigma is produced alongside it. One instance serves one scale; a multi-scale denoiser places one instance per scale.

The first block after reset fills the whole ring, so a full-window estimate is available at once. Later blocks enter the ring only while tuning is enabled and the block was flagged free of spikes.

Top module: `noise_sigma_est`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first estimate, `sigma`, `thresh` and `est_valid` are all 0.
- R2: A block's partial energy is the plain sum of `samp*samp`, with `samp` as a signed two's complement value, over every cycle with `samp_valid` high. This includes the cycle carrying `blk_end`. No mean is subtracted, and cycles with `samp_valid` low add nothing.
- R3: The first `blk_end` after reset writes that block's partial energy into all `R_SIG` ring slots, whatever `tune_en` and `spike_flag` are.
- R4: A later block enters the ring only when `tune_en` is 1 and `spike_flag` is 0 in its `blk_end` cycle. Otherwise the ring, and so the next estimate, is unchanged.
- R5: A committed block replaces the oldest slot. The window energy E is the sum of the `R_SIG` most recent committed partial energies, with seeded slots counting as committed.
- R6: The variance is floor(E * floor(2^FRAC / (BLK_LEN*R_SIG - 1)) / 2^FRAC). With the defaults this is floor(E*1040/65536).
- R7: `sigma` = floor(sqrt(variance)). `est_valid` is a one-cycle pulse, driven by the clock edge that lies `RW+1` edges after the edge that samples `blk_end` (16 with the defaults). An estimate follows every block end, committed or not.
- R8: `thresh` = floor(sigma * THR_Q8 / 256), with `THR_Q8` = 998 (about 3.9). It is updated together with `sigma`.
- R9: Partial and window energies are wide enough for full-scale samples of either sign, without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Qualifies `samp` this cycle |
| samp | input | W | Signed detail coefficient |
| blk_end | input | 1 | Marks the last cycle of a block |
| tune_en | input | 1 | Allows ring updates after the first block; sampled with `blk_end` |
| spike_flag | input | 1 | Block contains spikes; sampled with `blk_end` |
| sigma | output | RW | Noise standard deviation estimate |
| thresh | output | RW+2 | Scaled denoising threshold |
| est_valid | output | 1 | One-cycle pulse when `sigma`/`thresh` update |

## Verification
A corrupted ring slot or write pointer does not show up at once. It surfaces in the `sigma` of the next estimate, 16 cycles after the block end. A wrong pointer often shows only when a later commit wraps around and overwrites the wrong slot, so the stimulus runs through more than `R_SIG` commits. A gating fault (spike or tune ignored, seeding missing) changes the very next estimate. A fault in the accumulator or the reciprocal shifts every value after the first block, and a fault in the square-root sequencing moves the `est_valid` cycle.

// File: rtl/nse_pkg.sv
package nse_pkg;
  localparam int THR_FRAC = 8;

  typedef enum logic [0:0] {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} sq_state_e;

  // fixed-point reciprocal floor(2^frac / n), evaluated at elaboration
  function automatic longint unsigned recip_q(input longint unsigned n, input int frac);
    return (64'd1 << frac) / n;
  endfunction
endpackage

// File: rtl/nse_blk_accum.sv
module nse_blk_accum #(
  parameter int W  = 12,
  parameter int PW = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_valid,
  input  logic signed [W-1:0] samp,
  input  logic                blk_end,
  output logic [PW-1:0]       blk_sum
);
  logic signed [2*W-1:0] prod;
  logic [2*W-1:0]        sq_u;
  logic [PW-1:0]         acc_q;

  always_comb begin
    prod    = samp * samp;
    sq_u    = samp_valid ? prod : '0;
    blk_sum = acc_q + PW'(sq_u);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (blk_end) acc_q <= '0;
    else              acc_q <= blk_sum;
  end

  // R2/R9: inside a block the running energy never decreases (no wrap)
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_end |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/nse_ring.sv
module nse_ring #(
  parameter int PW = 28,
  parameter int R  = 4,
  parameter int EW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_all,
  input  logic          wr_en,
  input  logic [PW-1:0] din,
  output logic [EW-1:0] energy
);
  localparam int IW = (R > 1) ? $clog2(R) : 1;

  logic [PW-1:0] slot_q [R];
  logic [IW-1:0] ptr_q;

  for (genvar gi = 0; gi < R; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot_q[gi] <= '0;
      else if (seed_all)                           slot_q[gi] <= din;
      else if (wr_en && (ptr_q == IW'(gi)))        slot_q[gi] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || seed_all) ptr_q <= '0;
    else if (wr_en)         ptr_q <= (ptr_q == IW'(R-1)) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    energy = '0;
    for (int i = 0; i < R; i++) energy = energy + EW'(slot_q[i]);
  end

  // R4: without a write the window energy holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_all || wr_en) |=> $stable(energy));
  // R3: seeding leaves every slot equal
  a_r3_seed: assert property (@(posedge clk) disable iff (!rst_n)
    seed_all |=> (slot_q[0] == slot_q[R-1]));
endmodule

// File: rtl/nse_isqrt.sv
module nse_isqrt #(
  parameter int XW = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XW-1:0]    x,
  output logic [XW/2-1:0]  root_o,
  output logic             done
);
  import nse_pkg::*;
  localparam int RW = XW / 2;
  localparam int CW = $clog2(RW + 1);

  sq_state_e     st_q;
  logic [XW-1:0] op_q, x_q;
  logic [RW:0]   rem_q;
  logic [RW-1:0] root_q, res_q;
  logic [CW-1:0] cnt_q;
  logic [RW+2:0] rem_sh, trial, rem_nxt;
  logic          ge;
  logic [RW-1:0] root_nxt;

  always_comb begin
    rem_sh   = {rem_q, op_q[XW-1 -: 2]};
    trial    = {1'b0, root_q, 2'b01};
    ge       = (rem_sh >= trial);
    rem_nxt  = ge ? (rem_sh - trial) : rem_sh;
    root_nxt = {root_q[RW-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; op_q <= '0; x_q <= '0; rem_q <= '0;
      root_q <= '0; res_q <= '0; cnt_q <= '0; done <= 1'b0;
    end else if (start) begin
      st_q <= SQ_RUN; op_q <= x; x_q <= x; rem_q <= '0;
      root_q <= '0; cnt_q <= CW'(RW); done <= 1'b0;
    end else if (st_q == SQ_RUN) begin
      op_q   <= op_q << 2;
      rem_q  <= rem_nxt[RW:0];
      root_q <= root_nxt;
      cnt_q  <= cnt_q - 1'b1;
      done   <= (cnt_q == CW'(1));
      if (cnt_q == CW'(1)) begin
        res_q <= root_nxt;
        st_q  <= SQ_IDLE;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign root_o = res_q;

  logic [XW+1:0] res_w, sq_lo, sq_hi;
  always_comb begin
    res_w = (XW+2)'(res_q);
    sq_lo = res_w * res_w;
    sq_hi = (res_w + 1'b1) * (res_w + 1'b1);
  end

  // R7: result is the floor square root of the operand
  a_r7_floor_root: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((sq_lo <= (XW+2)'(x_q)) && (sq_hi > (XW+2)'(x_q))));
  // R7: completion is a single-cycle pulse
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/noise_sigma_est.sv
module noise_sigma_est #(
  parameter int W       = 12,
  parameter int BLK_LEN = 16,
  parameter int R_SIG   = 4,
  parameter int FRAC    = 16,
  parameter int THR_Q8  = 998,
  localparam int PW = 2*W + $clog2(BLK_LEN),
  localparam int EW = PW + $clog2(R_SIG),
  localparam int VW = EW + (EW % 2),
  localparam int RW = VW / 2,
  localparam int KW = $clog2(THR_Q8 + 1),
  localparam int TW = RW + KW - nse_pkg::THR_FRAC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_valid,
  input  logic signed [W-1:0] samp,
  input  logic                blk_end,
  input  logic                tune_en,
  input  logic                spike_flag,
  output logic [RW-1:0]       sigma,
  output logic [TW-1:0]       thresh,
  output logic                est_valid
);
  import nse_pkg::*;
  localparam longint unsigned RECIP = recip_q(BLK_LEN*R_SIG - 1, FRAC);
  localparam int SCW = EW + FRAC + 1;

  logic [PW-1:0] blk_sum;
  logic [EW-1:0] energy;
  logic [VW-1:0] var_w;
  logic          first_q, start_q, seed_all, commit;

  function automatic logic [VW-1:0] scale_var(input logic [EW-1:0] e);
    logic [SCW-1:0] p;
    p = SCW'(e) * SCW'(RECIP);
    return VW'(p >> FRAC);
  endfunction

  function automatic logic [TW-1:0] scale_thr(input logic [RW-1:0] s);
    logic [RW+KW-1:0] p;
    p = (RW+KW)'(s) * (RW+KW)'(THR_Q8);
    return TW'(p >> THR_FRAC);
  endfunction

  nse_blk_accum #(.W(W), .PW(PW)) u_acc (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp(samp),
    .blk_end(blk_end), .blk_sum(blk_sum));

  assign seed_all = blk_end && !first_q;
  assign commit   = blk_end && first_q && tune_en && !spike_flag;

  nse_ring #(.PW(PW), .R(R_SIG), .EW(EW)) u_ring (
    .clk(clk), .rst_n(rst_n), .seed_all(seed_all), .wr_en(commit),
    .din(blk_sum), .energy(energy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (blk_end) first_q <= 1'b1;
      start_q <= blk_end;
    end
  end

  assign var_w = scale_var(energy);

  nse_isqrt #(.XW(VW)) u_sqrt (
    .clk(clk), .rst_n(rst_n), .start(start_q), .x(var_w),
    .root_o(sigma), .done(est_valid));

  assign thresh = scale_thr(sigma);

  // R8: threshold lies between 3 and 4 times sigma
  a_r8_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> ((TW+2)'(thresh) >= (TW+2)'(sigma) * 3) &&
                  ((TW+2)'(thresh) <= (TW+2)'(sigma) * 4));
  // R7: an estimate follows a block end only after a start
  a_r7_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !est_valid);
endmodule

// File: tb/noise_sigma_est_bench.sv
module noise_sigma_est_bench;
  localparam int W = 12, BLK = 16, R = 4, FRAC = 16, K = 998;
  localparam int NV = 9;
  // {first sample, step, tune_en, spike_flag}
  localparam int VEC [0:NV-1][0:3] = '{
    '{  100,    3, 0, 1},
    '{ 2000,   -5, 1, 1},
    '{ -500,   20, 0, 0},
    '{-2048,    0, 1, 0},
    '{    0,    0, 1, 0},
    '{    7,   -1, 1, 0},
    '{ 1500, -200, 1, 0},
    '{  -30,    4, 1, 0},
    '{ 2047,    0, 1, 1}
  };

  logic clk = 0, rst_n = 0, samp_valid = 0, blk_end = 0, tune_en = 0, spike_flag = 0;
  logic signed [W-1:0] samp = '0;
  logic [14:0] sigma;
  logic [16:0] thresh;
  logic est_valid;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  longint ring [R];
  int ptr = 0;
  bit seeded = 0;

  always #10 clk = ~clk;

  noise_sigma_est u_noise_sigma_est (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp(samp),
    .blk_end(blk_end), .tune_en(tune_en), .spike_flag(spike_flag),
    .sigma(sigma), .thresh(thresh), .est_valid(est_valid));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint fsqrt(input longint v);
    longint r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic run_block(input int a, input int s, input int t, input int sp);
    longint p = 0, e = 0, v, sg;
    string tag;
    int k;
    for (int i = 0; i < BLK; i++) begin
      if (i == 5) begin
        samp_valid = 0; samp = -12'sd2048; blk_end = 0;   // R2: ignored cycle
        @(negedge clk);
      end
      samp_valid = 1;
      samp = W'(a + i*s);
      p += longint'(a + i*s) * longint'(a + i*s);
      blk_end = (i == BLK-1);
      tune_en = t[0];
      spike_flag = sp[0];
      @(negedge clk);
    end
    samp_valid = 0; blk_end = 0; samp = '0; tune_en = 0; spike_flag = 0;
    if (!seeded) begin
      tag = "R3";
      for (int j = 0; j < R; j++) ring[j] = p;
      ptr = 0; seeded = 1;
    end else if (t == 1 && sp == 0) begin
      tag = "R5";
      ring[ptr] = p; ptr = (ptr + 1) % R;
    end else begin
      tag = "R4";
    end
    for (int j = 0; j < R; j++) e += ring[j];
    v = (e * ((longint'(1) << FRAC) / (BLK*R - 1))) >> FRAC;   // R6
    sg = fsqrt(v);
    k = 1;
    while (!est_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    check("R7 latency", k, 17);
    check({tag, "/R6 sigma"}, sigma, sg);
    check("R8 thresh", thresh, (sg * K) / 256);
    @(negedge clk);
    check("R7 pulse width", est_valid, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < R; j++) ring[j] = 0;
    repeat (3) @(negedge clk);
    check("R1 sigma", sigma, 0);
    check("R1 thresh", thresh, 0);
    check("R1 valid", est_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after release", est_valid, 0);
    for (int n = 0; n < NV; n++) run_block(VEC[n][0], VEC[n][1], VEC[n][2], VEC[n][3]);
    // R1/R3: reset mid-run, then the first block seeds again despite spike and tune off
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 sigma mid-run", sigma, 0);
    check("R1 thresh mid-run", thresh, 0);
    rst_n = 1;
    seeded = 0; ptr = 0;
    for (int j = 0; j < R; j++) ring[j] = 0;
    run_block(-1000, 50, 0, 1);
    // R4: tune off after seed leaves the estimate unchanged
    run_block(2047, 0, 0, 0);
    // R9: full-scale negative block committed over whole window
    for (int n = 0; n < R; n++) run_block(-2048, 0, 1, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule